// File: doc/BRIEF.md
# Serial Control-Register Write Guard

This block sits behind the bit-level front end of a two-wire serial slave inside a supply supervisor. The front end reports bus events: a start condition, a stop condition, and a complete received byte. For each byte the block decides whether the acknowledge slot that follows is driven. It guards the supervisor's watchdog-period control register. A write reaches that register only after two enable latches have been raised in order and while the write-protect input is low. The block also recognises two trip-threshold programming commands, which act only while a high-voltage flag is present.

Each transaction has three bytes: a slave byte, an address byte and one data byte. Nothing happens while the bytes arrive. The block acts only when a stop condition follows exactly one accepted data byte. On that stop it updates the enable latches, or it loads the watchdog bits and issues a one-clock commit strobe, or it issues a one-clock trip-programming strobe. Any other framing is dropped without effect, for example an extra data byte, a repeated start, or a stop that arrives early.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset, `wel_o`, `rwel_o`, `ack_o`, `commit_o`, `set_trip_o` and `reset_trip_o` are 0, and `wd_o` equals the parameter `WD_INIT` (default 2'b00).
- R2: A slave byte that follows a start is acknowledged in two cases: its upper nibble is 1011b with bit 0 clear (register path), or it equals A0h (trip path). Any other slave byte is not acknowledged, and no later byte of that transaction is acknowledged. `ack_o` is a one-clock pulse in the cycle after the byte event.
- R3: On the register path, the 9-bit register address is slave-byte bit 1 (as address bit 8) joined with the address byte. The address byte is always acknowledged. The data byte is acknowledged, and the write can take effect, only when the address is 1FFh.
- R4: When `rwel_o` is 0, a register write whose data has bit 1 set and bit 2 clear sets `wel_o`. With `rwel_o` at 0, data 00h clears `wel_o`. Other data with bit 2 clear leaves every output unchanged.
- R5: A register write whose data has bit 2 set sets `rwel_o` only when bit 1 is also set and `wel_o` is already 1. Otherwise it has no effect (06h is the enabling value).
- R6: When `rwel_o` is 1, a register write with data bit 2 clear and `wp_in` low loads `wd_o` with {data bit 7, data bit 4} and clears `rwel_o`. If the data is 00h, it also clears `wel_o`.
- R7: Only the first data byte of a transaction is acknowledged. A transaction that carries a second data byte does nothing at its stop.
- R8: Changes take effect only on the stop that closes an accepted transaction. `commit_o` pulses for exactly one clock, in the cycle after that stop, whenever R6 loads `wd_o`. It is never high in any other cycle.
- R9: While `wp_in` is high at the stop, a write that R6 would otherwise commit leaves `wd_o` and `rwel_o` unchanged, and no commit pulse is issued.
- R10: Slave A0h, address 01h and data 00h, closed by a stop while `hv_in` is high, give a one-clock `set_trip_o` pulse in the cycle after the stop. Without `hv_in`, or with other data, there is no pulse.
- R11: Slave A0h, address 03h and data 00h, closed by a stop while `hv_in` is high, give a one-clock `reset_trip_o` pulse. On the trip path the data byte is acknowledged only for address 01h or 03h.
- R12: A start in the middle of a transaction abandons it. A stop after that start has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | One-clock start-condition event |
| ev_stop | input | 1 | One-clock stop-condition event |
| ev_byte | input | 1 | One-clock byte-received event |
| rx_byte | input | 8 | Received byte, valid with `ev_byte` |
| wp_in | input | 1 | Write protect; high blocks watchdog-bit changes |
| hv_in | input | 1 | Programming high voltage present on protect pin |
| ack_o | output | 1 | Acknowledge decision pulse for the last byte |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write-enable latch |
| wd_o | output | 2 | Watchdog period bits {bit 7, bit 4 of data} |
| commit_o | output | 1 | One-clock nonvolatile commit strobe |
| set_trip_o | output | 1 | One-clock set-threshold strobe |
| reset_trip_o | output | 1 | One-clock reset-threshold strobe |

## Verification
The bench attacks the enable ordering. It writes the RWEL value before WEL is set, and it writes data before RWEL is set. A guard that skips the ordering would set RWEL early or change the watchdog bits. It checks that nothing commits at the data byte and that the strobe lasts one clock, so a design that commits too early or holds the strobe would be seen. It sends a second data byte, a repeated start, a wrong address-bit-8 and a protected write, and each of these must leave `wd_o` unchanged. It also drives trip commands with the high voltage absent, with nonzero data and with an unknown address, and each must give no strobe.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
   typedef enum logic [2:0] {
      FS_IDLE, FS_SLAVE, FS_ADDR, FS_DATA, FS_DONE, FS_SKIP
   } frame_st_t;

   typedef enum logic [1:0] {
      TGT_NONE, TGT_CTRL, TGT_SET, TGT_RST
   } target_t;

   localparam int unsigned WD_HI_BIT  = 7;
   localparam int unsigned WD_LO_BIT  = 4;
   localparam int unsigned RWEL_BIT   = 2;
   localparam int unsigned WEL_BIT    = 1;
endpackage

// File: rtl/cwg_frame.sv
module cwg_frame
   import cwg_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 9,
   parameter logic [3:0]         CTRL_ID   = 4'hB,
   parameter logic [ADDR_W-1:0]  CTRL_ADDR = '1,
   parameter logic [7:0]         TRIP_ID   = 8'hA0,
   parameter logic [7:0]         SET_ADDR  = 8'h01,
   parameter logic [7:0]         RST_ADDR  = 8'h03,
   parameter bit                 TRIP_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] byte_in,
   output logic       ack_o,
   output logic       fin_ctrl_o,
   output logic       fin_set_o,
   output logic       fin_rst_o,
   output logic [7:0] data_o
);
   localparam int unsigned HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr_w
         $error("cwg_frame: ADDR_W must lie in 9..11");
      end
   endgenerate

   frame_st_t        st_q;
   target_t          tgt_q;
   logic             is_ctrl_q;
   logic [HI_W-1:0]  hi_q;
   logic [7:0]       data_q;
   logic             ack_q;
   logic             ctrl_hit;
   logic             trip_hit;

   assign ctrl_hit = (byte_in[7:4] == CTRL_ID) && !byte_in[0];

   generate
      if (TRIP_EN) begin : g_trip_dec
         assign trip_hit = (byte_in == TRIP_ID);
      end else begin : g_no_trip_dec
         assign trip_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FS_IDLE;
         tgt_q     <= TGT_NONE;
         is_ctrl_q <= 1'b0;
         hi_q      <= '0;
         data_q    <= '0;
         ack_q     <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         if (ev_start) begin
            st_q  <= FS_SLAVE;
            tgt_q <= TGT_NONE;
         end else if (ev_stop) begin
            st_q <= FS_IDLE;
         end else if (ev_byte) begin
            unique case (st_q)
               FS_SLAVE: begin
                  if (ctrl_hit) begin
                     is_ctrl_q <= 1'b1;
                     hi_q      <= byte_in[HI_W:1];
                     ack_q     <= 1'b1;
                     st_q      <= FS_ADDR;
                  end else if (trip_hit) begin
                     is_ctrl_q <= 1'b0;
                     ack_q     <= 1'b1;
                     st_q      <= FS_ADDR;
                  end else begin
                     st_q <= FS_SKIP;
                  end
               end
               FS_ADDR: begin
                  ack_q <= 1'b1;
                  if (is_ctrl_q && ({hi_q, byte_in} == CTRL_ADDR)) begin
                     tgt_q <= TGT_CTRL;
                     st_q  <= FS_DATA;
                  end else if (!is_ctrl_q && byte_in == SET_ADDR) begin
                     tgt_q <= TGT_SET;
                     st_q  <= FS_DATA;
                  end else if (!is_ctrl_q && byte_in == RST_ADDR) begin
                     tgt_q <= TGT_RST;
                     st_q  <= FS_DATA;
                  end else begin
                     st_q <= FS_SKIP;
                  end
               end
               FS_DATA: begin
                  ack_q  <= 1'b1;
                  data_q <= byte_in;
                  st_q   <= FS_DONE;
               end
               FS_DONE: st_q <= FS_SKIP;
               default: st_q <= st_q;
            endcase
         end
      end
   end

   logic closing;
   assign closing    = ev_stop && !ev_start && (st_q == FS_DONE);
   assign fin_ctrl_o = closing && (tgt_q == TGT_CTRL);
   assign fin_set_o  = closing && (tgt_q == TGT_SET);
   assign fin_rst_o  = closing && (tgt_q == TGT_RST);
   assign data_o     = data_q;
   assign ack_o      = ack_q;

   // R2: acknowledge only ever answers a byte event
   p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(ev_byte));

   // R7: a byte after the accepted data byte is never acknowledged
   p_one_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_byte && !ev_start && !ev_stop && st_q == FS_DONE) |=> !ack_o);

   // R12: a start always reopens the frame at the slave byte
   p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> (st_q == FS_SLAVE));
endmodule

// File: rtl/cwg_latches.sv
module cwg_latches
   import cwg_pkg::*;
#(
   parameter logic [1:0] WD_INIT = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fin_ctrl,
   input  logic [7:0] data_in,
   input  logic       wp_in,
   output logic       wel_o,
   output logic       rwel_o,
   output logic [1:0] wd_o,
   output logic       commit_o
);
   logic       wel_q, rwel_q, commit_q;
   logic [1:0] wd_q;
   logic       is_zero;

   assign is_zero = (data_in == 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q    <= 1'b0;
         rwel_q   <= 1'b0;
         wd_q     <= WD_INIT;
         commit_q <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (fin_ctrl) begin
            if (rwel_q && !data_in[RWEL_BIT]) begin
               if (!wp_in) begin
                  wd_q     <= {data_in[WD_HI_BIT], data_in[WD_LO_BIT]};
                  commit_q <= 1'b1;
                  rwel_q   <= 1'b0;
                  if (is_zero) wel_q <= 1'b0;
               end
            end else if (data_in[RWEL_BIT]) begin
               if (data_in[WEL_BIT] && wel_q) rwel_q <= 1'b1;
            end else if (data_in[WEL_BIT]) begin
               wel_q <= 1'b1;
            end else if (is_zero) begin
               wel_q <= 1'b0;
            end
         end
      end
   end

   assign wel_o    = wel_q;
   assign rwel_o   = rwel_q;
   assign wd_o     = wd_q;
   assign commit_o = commit_q;

   // R5: the second latch only rises on top of the first
   p_rwel_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rwel_o) |-> $past(wel_o));

   // R6: watchdog bits move only together with a commit strobe
   p_wd_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wd_o) |-> commit_o);

   // R8: commit strobe lasts one clock
   p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o);

   // R9: nothing commits while protect was high
   p_wp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> !$past(wp_in));
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard #(
   parameter int unsigned        ADDR_W    = 9,
   parameter logic [3:0]         CTRL_ID   = 4'hB,
   parameter logic [ADDR_W-1:0]  CTRL_ADDR = '1,
   parameter logic [7:0]         TRIP_ID   = 8'hA0,
   parameter logic [7:0]         SET_ADDR  = 8'h01,
   parameter logic [7:0]         RST_ADDR  = 8'h03,
   parameter bit                 TRIP_EN   = 1'b1,
   parameter logic [1:0]         WD_INIT   = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] rx_byte,
   input  logic       wp_in,
   input  logic       hv_in,
   output logic       ack_o,
   output logic       wel_o,
   output logic       rwel_o,
   output logic [1:0] wd_o,
   output logic       commit_o,
   output logic       set_trip_o,
   output logic       reset_trip_o
);
   logic       fin_ctrl, fin_set, fin_rst;
   logic [7:0] frame_data;

   cwg_frame #(
      .ADDR_W(ADDR_W), .CTRL_ID(CTRL_ID), .CTRL_ADDR(CTRL_ADDR),
      .TRIP_ID(TRIP_ID), .SET_ADDR(SET_ADDR), .RST_ADDR(RST_ADDR),
      .TRIP_EN(TRIP_EN)
   ) u_frame (
      .clk(clk), .rst_n(rst_n),
      .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte),
      .byte_in(rx_byte), .ack_o(ack_o),
      .fin_ctrl_o(fin_ctrl), .fin_set_o(fin_set), .fin_rst_o(fin_rst),
      .data_o(frame_data)
   );

   cwg_latches #(.WD_INIT(WD_INIT)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .fin_ctrl(fin_ctrl), .data_in(frame_data), .wp_in(wp_in),
      .wel_o(wel_o), .rwel_o(rwel_o), .wd_o(wd_o), .commit_o(commit_o)
   );

   generate
      if (TRIP_EN) begin : g_trip
         logic set_q, rst_q, go;
         assign go = hv_in && (frame_data == 8'h00);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               set_q <= 1'b0;
               rst_q <= 1'b0;
            end else begin
               set_q <= fin_set && go;
               rst_q <= fin_rst && go;
            end
         end
         assign set_trip_o   = set_q;
         assign reset_trip_o = rst_q;
      end else begin : g_no_trip
         assign set_trip_o   = 1'b0;
         assign reset_trip_o = 1'b0;
      end
   endgenerate

   // R10: trip strobes need the high voltage at the closing stop
   p_trip_hv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_trip_o || reset_trip_o) |-> ($past(hv_in) && $past(ev_stop)));

   // R11: the two trip strobes never coincide
   p_trip_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_trip_o, reset_trip_o, commit_o}));
endmodule

// File: tb/sim_cfg_write_guard.sv
module sim_cfg_write_guard;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       wp_in = 1'b0, hv_in = 1'b0;
   logic       ack_o, wel_o, rwel_o, commit_o, set_trip_o, reset_trip_o;
   logic [1:0] wd_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_write_guard u0 (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .rx_byte(rx_byte), .wp_in(wp_in), .hv_in(hv_in),
      .ack_o(ack_o), .wel_o(wel_o), .rwel_o(rwel_o), .wd_o(wd_o),
      .commit_o(commit_o), .set_trip_o(set_trip_o), .reset_trip_o(reset_trip_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_start();
      @(negedge clk); ev_start = 1'b1;
      @(negedge clk); ev_start = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] b, input bit exp_ack, input string tag);
      @(negedge clk); ev_byte = 1'b1; rx_byte = b;
      @(negedge clk); ev_byte = 1'b0;
      chk(ack_o == exp_ack, tag, ack_o, exp_ack);
   endtask

   // returns strobes seen in the cycle after the stop; checks they drop next
   task automatic do_stop(output logic c, output logic s, output logic r);
      @(negedge clk); ev_stop = 1'b1;
      @(negedge clk); ev_stop = 1'b0;
      c = commit_o; s = set_trip_o; r = reset_trip_o;
      @(negedge clk);
      chk(!(commit_o || set_trip_o || reset_trip_o), "R8 strobe one clock",
          {commit_o, set_trip_o, reset_trip_o}, 0);
   endtask

   task automatic ctrl_wr(input logic [7:0] d, input bit exp_commit, input string tag);
      logic c, s, r;
      do_start();
      do_byte(8'hB2, 1'b1, "R2 ctrl slave ack");
      do_byte(8'hFF, 1'b1, "R3 addr ack");
      do_byte(d, 1'b1, "R3 data ack");
      chk(commit_o == 1'b0, "R8 no commit before stop", commit_o, 0);
      do_stop(c, s, r);
      chk(c == exp_commit, tag, c, exp_commit);
   endtask

   task automatic t_reset();
      chk(wel_o == 0 && rwel_o == 0, "R1 latches clear", {wel_o, rwel_o}, 0);
      chk(wd_o == 2'b00, "R1 wd init", wd_o, 0);
      chk(!(ack_o || commit_o || set_trip_o || reset_trip_o), "R1 outputs idle",
          {ack_o, commit_o, set_trip_o, reset_trip_o}, 0);
   endtask

   task automatic t_order();
      ctrl_wr(8'h06, 1'b0, "R5 early rwel no commit");
      chk(rwel_o == 0, "R5 rwel needs wel", rwel_o, 0);
      ctrl_wr(8'h02, 1'b0, "R4 set wel no commit");
      chk(wel_o == 1, "R4 wel set", wel_o, 1);
      ctrl_wr(8'h90, 1'b0, "R6 no commit without rwel");
      chk(wd_o == 2'b00 && wel_o == 1, "R4 other data ignored", {wel_o, wd_o}, 3'b100);
      ctrl_wr(8'h06, 1'b0, "R5 rwel write no commit");
      chk(rwel_o == 1, "R5 rwel set", rwel_o, 1);
   endtask

   task automatic t_commit();
      ctrl_wr(8'h90, 1'b1, "R8 commit pulse");
      chk(wd_o == 2'b11, "R6 wd loaded", wd_o, 3);
      chk(rwel_o == 0 && wel_o == 1, "R6 rwel cleared wel kept", {wel_o, rwel_o}, 2);
   endtask

   task automatic t_protect();
      ctrl_wr(8'h06, 1'b0, "R5 rearm");
      wp_in = 1'b1;
      ctrl_wr(8'h10, 1'b0, "R9 protected no commit");
      chk(wd_o == 2'b11 && rwel_o == 1, "R9 state kept", {rwel_o, wd_o}, 3'b111);
      wp_in = 1'b0;
      ctrl_wr(8'h10, 1'b1, "R9 unprotected commit");
      chk(wd_o == 2'b01, "R6 wd from bits 7,4", wd_o, 1);
   endtask

   task automatic t_extra_byte();
      logic c, s, r;
      ctrl_wr(8'h06, 1'b0, "R5 rearm2");
      do_start();
      do_byte(8'hB2, 1'b1, "R2 slave");
      do_byte(8'hFF, 1'b1, "R3 addr");
      do_byte(8'h80, 1'b1, "R7 first data ack");
      do_byte(8'h00, 1'b0, "R7 second data nack");
      do_stop(c, s, r);
      chk(c == 0 && wd_o == 2'b01 && rwel_o == 1, "R7 extra byte kills write",
          {c, rwel_o, wd_o}, 4'b0101);
   endtask

   task automatic t_restart();
      logic c, s, r;
      do_start();
      do_byte(8'hB2, 1'b1, "R2 slave");
      do_byte(8'hFF, 1'b1, "R3 addr");
      do_byte(8'h80, 1'b1, "R3 data");
      do_start();
      do_stop(c, s, r);
      chk(c == 0 && wd_o == 2'b01, "R12 restart abandons", {c, wd_o}, 1);
   endtask

   task automatic t_badaddr();
      logic c, s, r;
      do_start();
      do_byte(8'hB0, 1'b1, "R2 slave bit1 clear");
      do_byte(8'hFF, 1'b1, "R3 addr always acked");
      do_byte(8'h80, 1'b0, "R3 wrong bit8 data nack");
      do_stop(c, s, r);
      chk(c == 0 && wd_o == 2'b01, "R3 wrong addr no write", {c, wd_o}, 1);
      do_start();
      do_byte(8'h50, 1'b0, "R2 foreign slave nack");
      do_byte(8'hFF, 1'b0, "R2 rest of frame nack");
      do_stop(c, s, r);
      do_start();
      do_byte(8'hB3, 1'b0, "R2 read bit nack");
      do_stop(c, s, r);
   endtask

   task automatic t_clear();
      ctrl_wr(8'h00, 1'b1, "R6 zero data commits");
      chk(wd_o == 0 && wel_o == 0 && rwel_o == 0, "R6 zero clears wel",
          {wel_o, rwel_o, wd_o}, 0);
      ctrl_wr(8'h02, 1'b0, "R4 set wel again");
      ctrl_wr(8'h00, 1'b0, "R4 clear no commit");
      chk(wel_o == 0, "R4 wel cleared by 00h", wel_o, 0);
   endtask

   task automatic trip(input logic [7:0] a, input logic [7:0] d, input bit data_ack,
                       input bit exp_s, input bit exp_r, input string tag);
      logic c, s, r;
      do_start();
      do_byte(8'hA0, 1'b1, "R2 trip slave ack");
      do_byte(a, 1'b1, "R11 trip addr ack");
      do_byte(d, data_ack, "R11 trip data ack");
      do_stop(c, s, r);
      chk(s == exp_s && r == exp_r && c == 0, tag, {c, s, r}, {1'b0, exp_s, exp_r});
   endtask

   task automatic t_trip();
      hv_in = 1'b0;
      trip(8'h01, 8'h00, 1'b1, 1'b0, 1'b0, "R10 no hv no set");
      hv_in = 1'b1;
      trip(8'h01, 8'h00, 1'b1, 1'b1, 1'b0, "R10 set trip pulse");
      trip(8'h03, 8'h00, 1'b1, 1'b0, 1'b1, "R11 reset trip pulse");
      trip(8'h02, 8'h00, 1'b0, 1'b0, 1'b0, "R11 unknown addr");
      trip(8'h01, 8'h05, 1'b1, 1'b0, 1'b0, "R10 nonzero data");
      hv_in = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_commit();
      t_protect();
      t_extra_byte();
      t_restart();
      t_badaddr();
      t_clear();
      t_trip();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule